// File: doc/BRIEF.md
# Interrupt-Sensing GPIO Port

This block is a 16-pin general-purpose I/O port behind a small memory-mapped register bus. Software reaches a pin data register and five per-pin configuration words: direction, input enable, polarity, edge select and dual-edge select. It also reaches two independent interrupt mask words. The data word and both mask words each take up four consecutive register slots. The slots are a plain load, an atomic clear, an atomic set and an atomic toggle, so single bits can change without a read-modify-write sequence.

External pin levels pass through a two-flop synchronizer. A pin counts as an input only when its direction bit and its input-enable bit are both set. For such a pin, the data bit follows the synchronized level, and the level is checked against that pin's sensing rule. The rule is level, single edge or either edge, with a selectable polarity. A qualifying pin drives interrupt line A when its A-mask bit is set and line B when its B-mask bit is set, and it may drive both.

The bus accepts one access per cycle and has no back-pressure; the block never stalls a request. Each access gets a registered response one cycle later, carrying read data and an error flag.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0, and both interrupt outputs and the response outputs are 0.
- R2: Registers sit at byte offsets 4*k for k = 0..16, in this order: data, data-clear, data-set, data-toggle, maskA, maskA-clear, maskA-set, maskA-toggle, maskB, maskB-clear, maskB-set, maskB-toggle, dir, polar, edge, both, inen. A read of any of the four data slots returns the data word, and likewise for the maskA and maskB slots. Each configuration slot reads back its own value.
- R3: A write to the data, maskA, maskB or any configuration slot replaces the whole word.
- R4: A write to a clear slot clears the bits written as 1. A write to a set slot ORs the value in. A write to a toggle slot XORs the value in.
- R5: An access whose size code is not 2'b01 (16-bit) is an error. So is an offset with nonzero bits [1:0], or an offset at or above 0x44. An error response has rsp_err=1 and rsp_rdata=0, and the access changes no register.
- R6: Every cycle with bus_vld=1 produces rsp_vld=1 on the next cycle, and rsp_vld is 0 otherwise. For a legal read, rsp_rdata carries the register value.
- R7: A pin whose dir and inen bits are not both 1 does not update its data bit and raises no interrupt. Its data bit stays under software control. For an enabled pin, the pin level overrides any software write to that data bit.
- R8: A pin change presented before clock edge n shows up in the data word and on the interrupt outputs after edge n+2.
- R9: With the edge bit 0, an enabled pin qualifies on every cycle in which its synchronized level differs from its polar bit. Polar 0 means active-high and polar 1 means active-low.
- R10: With edge=1 and both=0, polar=0 selects rising transitions and polar=1 selects falling transitions. Each transition gives a one-cycle pulse.
- R11: With edge=1 and both=1, every transition of the pin gives a one-cycle pulse.
- R12: A qualifying pin drives irq_a if its maskA bit is 1 and drives irq_b if its maskB bit is 1. Both may fire for the same event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_vld | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset in the register window |
| bus_size | input | 2 | Access size code: 00 8-bit, 01 16-bit, 10 32-bit |
| bus_wdata | input | 16 | Write data |
| rsp_vld | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Illegal size or offset |
| rsp_rdata | output | 16 | Read data |
| pins_in | input | 16 | Asynchronous external pin levels |
| irq_a | output | 1 | Interrupt line A |
| irq_b | output | 1 | Interrupt line B |

## Verification
The sensing path is swept over every pin, every one of the five sensing modes and both transition directions. The mask choice rotates with the pin index, so that A-only, B-only, both and neither routing are all exercised on each mode. Edge modes are checked by counting pulses across a window, which separates a single pulse from a missed or repeated one. Level modes are checked on the settled output level, which separates the two polarities. Separate cases drive pins with only direction or only input enable set, to show that both gate bits are needed. A cycle-by-cycle trace of one rising edge pins down the synchronizer latency. The register tests run a chain of load, set, clear and toggle writes whose expected values differ at each step, read each word back through all of its alias slots, and present illegal sizes and offsets so that an erroneous write would be visible on readback.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W    = 7;
  localparam int IDX_W     = 5;
  localparam int REG_COUNT = 17;
  localparam int CFG_COUNT = 5;

  localparam logic [1:0] SIZE_HALF = 2'b01;

  localparam logic [IDX_W-1:0] IDX_DATA  = 5'd0;
  localparam logic [IDX_W-1:0] IDX_MSKA  = 5'd4;
  localparam logic [IDX_W-1:0] IDX_MSKB  = 5'd8;
  localparam logic [IDX_W-1:0] IDX_CFG0  = 5'd12;
  localparam logic [IDX_W-1:0] IDX_LIMIT = 5'd17;

  // config word positions inside the configuration bank
  localparam int CFG_DIR   = 0;
  localparam int CFG_POLAR = 1;
  localparam int CFG_EDGE  = 2;
  localparam int CFG_BOTH  = 3;
  localparam int CFG_INEN  = 4;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_CLR  = 2'd1,
    OP_SET  = 2'd2,
    OP_TGL  = 2'd3
  } alias_op_e;

  typedef struct packed {
    logic             hit;
    logic             err;
    logic [IDX_W-1:0] idx;
  } bus_dec_t;
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_port_pkg::*;
(
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output bus_dec_t          dec
);
  logic bad_size, bad_align, bad_range;

  always_comb begin
    bad_size   = (req_size != SIZE_HALF);
    bad_align  = (req_addr[1:0] != 2'b00);
    bad_range  = (req_addr[ADDR_W-1:2] >= IDX_LIMIT);
    dec.idx    = req_addr[ADDR_W-1:2];
    dec.err    = req_vld && (bad_size || bad_align || bad_range);
    dec.hit    = req_vld && !(bad_size || bad_align || bad_range);
  end
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_port_pkg::*;
#(
  parameter int               W         = 16,
  parameter logic [IDX_W-1:0] BASE_IDX  = 5'd0,
  parameter bit               HAS_ALIAS = 1'b1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [W-1:0]     hw_mask,
  input  logic [W-1:0]     hw_val,
  output logic [W-1:0]     q
);
  logic      in_grp;
  alias_op_e op;
  logic [W-1:0] sw_next, q_next;

  generate
    if (HAS_ALIAS) begin : g_alias
      always_comb begin
        in_grp = (wr_idx[IDX_W-1:2] == BASE_IDX[IDX_W-1:2]);
        op     = alias_op_e'(wr_idx[1:0]);
      end
    end else begin : g_plain
      always_comb begin
        in_grp = (wr_idx == BASE_IDX);
        op     = OP_LOAD;
      end
    end
  endgenerate

  always_comb begin
    sw_next = q;
    if (wr_en && in_grp) begin
      unique case (op)
        OP_LOAD: sw_next = wr_data;
        OP_CLR:  sw_next = q & ~wr_data;
        OP_SET:  sw_next = q | wr_data;
        OP_TGL:  sw_next = q ^ wr_data;
        default: sw_next = q;
      endcase
    end
    q_next = (sw_next & ~hw_mask) | (hw_val & hw_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  // R4: bits set through the set slot read as 1 unless hardware owns them
  a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_grp && op == OP_SET) |=>
      ((q & $past(wr_data) & ~$past(hw_mask)) == ($past(wr_data) & ~$past(hw_mask))));

  // R4: bits cleared through the clear slot read as 0 unless hardware owns them
  a_r4_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_grp && op == OP_CLR) |=>
      ((q & $past(wr_data) & ~$past(hw_mask)) == '0));
endmodule

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense #(
  parameter int W = 16
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_async,
  input  logic [W-1:0] enabled,
  input  logic [W-1:0] polar,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] both_sel,
  output logic [W-1:0] level,
  output logic [W-1:0] qual
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic rise, fall, edge_hit, lvl_hit;
      always_comb begin
        rise     = sync_q[i] & ~prev_q[i];
        fall     = ~sync_q[i] & prev_q[i];
        edge_hit = both_sel[i] ? (rise | fall) : (polar[i] ? fall : rise);
        lvl_hit  = sync_q[i] ^ polar[i];
        qual[i]  = enabled[i] & (edge_sel[i] ? edge_hit : lvl_hit);
      end
    end
  endgenerate

  // R7: a pin that was not enabled never qualifies
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((qual & ~enabled) == '0));

  // R10: in single-edge rising mode a steady high level after the edge stops qualifying
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(qual[0]) && $stable(edge_sel) && $stable(both_sel) && $stable(polar)
      && edge_sel[0] && $stable(sync_q[0])) |-> !qual[0]);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int PIN_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_vld,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [PIN_W-1:0]  bus_wdata,
  output logic              rsp_vld,
  output logic              rsp_err,
  output logic [PIN_W-1:0]  rsp_rdata,
  input  logic [PIN_W-1:0]  pins_in,
  output logic              irq_a,
  output logic              irq_b
);
  bus_dec_t dec;
  logic     reg_we;
  logic [PIN_W-1:0] data_q, mska_q, mskb_q;
  logic [PIN_W-1:0] cfg_q [CFG_COUNT];
  logic [PIN_W-1:0] hw_own, pin_lvl, pin_qual, rd_mux;
  logic             data_grp_we;

  gpio_bus_decode u_dec (
    .req_vld (bus_vld),
    .req_addr(bus_addr),
    .req_size(bus_size),
    .dec     (dec)
  );

  assign reg_we      = dec.hit && bus_wr;
  assign data_grp_we = reg_we && (dec.idx[IDX_W-1:2] == IDX_DATA[IDX_W-1:2]);
  assign hw_own      = cfg_q[CFG_DIR] & cfg_q[CFG_INEN];

  gpio_alias_reg #(.W(PIN_W), .BASE_IDX(IDX_DATA), .HAS_ALIAS(1'b1)) u_data (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_idx(dec.idx), .wr_data(bus_wdata),
    .hw_mask(hw_own), .hw_val(pin_lvl), .q(data_q)
  );

  gpio_alias_reg #(.W(PIN_W), .BASE_IDX(IDX_MSKA), .HAS_ALIAS(1'b1)) u_mska (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_idx(dec.idx), .wr_data(bus_wdata),
    .hw_mask('0), .hw_val('0), .q(mska_q)
  );

  gpio_alias_reg #(.W(PIN_W), .BASE_IDX(IDX_MSKB), .HAS_ALIAS(1'b1)) u_mskb (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_idx(dec.idx), .wr_data(bus_wdata),
    .hw_mask('0), .hw_val('0), .q(mskb_q)
  );

  generate
    for (genvar c = 0; c < CFG_COUNT; c++) begin : g_cfg
      gpio_alias_reg #(.W(PIN_W), .BASE_IDX(IDX_CFG0 + 5'(c)), .HAS_ALIAS(1'b0)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_idx(dec.idx), .wr_data(bus_wdata),
        .hw_mask('0), .hw_val('0), .q(cfg_q[c])
      );
    end
  endgenerate

  gpio_pin_sense #(.W(PIN_W)) u_sense (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_async(pins_in),
    .enabled   (hw_own),
    .polar     (cfg_q[CFG_POLAR]),
    .edge_sel  (cfg_q[CFG_EDGE]),
    .both_sel  (cfg_q[CFG_BOTH]),
    .level     (pin_lvl),
    .qual      (pin_qual)
  );

  always_comb begin
    rd_mux = '0;
    unique case (dec.idx[IDX_W-1:2])
      3'd0:    rd_mux = data_q;
      3'd1:    rd_mux = mska_q;
      3'd2:    rd_mux = mskb_q;
      3'd3:    rd_mux = cfg_q[dec.idx[1:0]];
      3'd4:    rd_mux = cfg_q[CFG_INEN];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      irq_a     <= 1'b0;
      irq_b     <= 1'b0;
    end else begin
      rsp_vld   <= bus_vld;
      rsp_err   <= dec.err;
      rsp_rdata <= (dec.hit && !bus_wr) ? rd_mux : '0;
      irq_a     <= |(pin_qual & mska_q);
      irq_b     <= |(pin_qual & mskb_q);
    end
  end

  // R6: one response per request, one cycle later
  a_r6_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_vld |=> rsp_vld);
  a_r6_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_vld |=> !rsp_vld);
  // R5: an error only comes with a response and carries no data
  a_r5_err_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_vld && rsp_rdata == '0));
  // R12: an interrupt line only rises through a nonzero mask
  a_r12_irq_a_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> ($past(mska_q) != '0));
  a_r12_irq_b_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b |-> ($past(mskb_q) != '0));
  // R7: data bits of pins not owned by hardware only move on a data write
  a_r7_sw_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(data_grp_we) |-> (((data_q ^ $past(data_q)) & ~$past(hw_own)) == '0));
endmodule

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
module test_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_vld = 1'b0, bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'b01;
  logic [15:0] bus_wdata = '0;
  logic        rsp_vld, rsp_err;
  logic [15:0] rsp_rdata;
  logic [15:0] pins_in = '0;
  logic        irq_a, irq_b;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .rsp_vld(rsp_vld), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .pins_in(pins_in), .irq_a(irq_a), .irq_b(irq_b)
  );

  localparam logic [6:0] A_DATA = 7'h00, A_MSKA = 7'h10, A_MSKB = 7'h20;
  localparam logic [6:0] A_DIR = 7'h30, A_POL = 7'h34, A_EDGE = 7'h38, A_BOTH = 7'h3C, A_INEN = 7'h40;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [6:0] a, input logic [1:0] sz,
                        input logic [15:0] d, output logic [15:0] rd, output logic er,
                        output logic rv);
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_vld = 1'b0;
    rd = rsp_rdata; er = rsp_err; rv = rsp_vld;
  endtask

  task automatic wr16(input logic [6:0] a, input logic [15:0] d);
    logic [15:0] rd; logic er, rv;
    access(1'b1, a, 2'b01, d, rd, er, rv);
  endtask

  task automatic rd16(input logic [6:0] a, output logic [15:0] rd);
    logic er, rv;
    access(1'b0, a, 2'b01, 16'h0, rd, er, rv);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one sweep point: pin p, mode m (0 lvl pol0, 1 lvl pol1, 2 rise, 3 fall, 4 both), start level s
  task automatic sense_case(input int p, input int m, input logic s);
    logic [15:0] bit_p, rd;
    logic pol, edg, bth, mA, mB, nw, hit;
    int ca, cb;
    bit_p = 16'h1 << p;
    pol = (m == 1) || (m == 3);
    edg = (m >= 2);
    bth = (m == 4);
    mA  = ((p % 4) == 0) || ((p % 4) == 2);
    mB  = ((p % 4) == 1) || ((p % 4) == 2);
    wr16(A_MSKA, 16'h0); wr16(A_MSKB, 16'h0);
    pins_in = s ? bit_p : 16'h0;
    wr16(A_DIR, bit_p); wr16(A_INEN, bit_p);
    wr16(A_POL, pol ? bit_p : 16'h0);
    wr16(A_EDGE, edg ? bit_p : 16'h0);
    wr16(A_BOTH, bth ? bit_p : 16'h0);
    idle(4);
    wr16(A_MSKA, mA ? bit_p : 16'h0);
    wr16(A_MSKB, mB ? bit_p : 16'h0);
    idle(2);
    nw = ~s;
    pins_in = nw ? bit_p : 16'h0;
    ca = 0; cb = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      ca += int'(irq_a); cb += int'(irq_b);
    end
    if (edg) begin
      hit = bth ? 1'b1 : (pol ? (s && !nw) : (!s && nw));
      check($sformatf("R10/R11/R12 pulses A p%0d m%0d s%0d", p, m, s), ca, (hit && mA) ? 1 : 0);
      check($sformatf("R10/R11/R12 pulses B p%0d m%0d s%0d", p, m, s), cb, (hit && mB) ? 1 : 0);
    end else begin
      hit = (nw != pol);
      check($sformatf("R9/R12 level A p%0d m%0d s%0d", p, m, s), irq_a, hit && mA);
      check($sformatf("R9/R12 level B p%0d m%0d s%0d", p, m, s), irq_b, hit && mB);
    end
    rd16(A_DATA, rd);
    check($sformatf("R7 data bit follows pin p%0d", p), rd[p], nw);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic er, rv;
    int cfg_a [5];
    logic [15:0] cfg_v [5];
    cfg_a[0] = 'h30; cfg_a[1] = 'h34; cfg_a[2] = 'h38; cfg_a[3] = 'h3C; cfg_a[4] = 'h40;
    cfg_v[0] = 16'hA5C3; cfg_v[1] = 16'h1234; cfg_v[2] = 16'hFEDC; cfg_v[3] = 16'h0F0F; cfg_v[4] = 16'h8001;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq_a at reset", irq_a, 0);
    check("R1 irq_b at reset", irq_b, 0);
    check("R1 rsp_vld at reset", rsp_vld, 0);
    for (int k = 0; k < 17; k++) begin
      rd16(7'(k * 4), rd);
      check($sformatf("R1 reg %0d zero", k), rd, 0);
    end

    // R2/R3: configuration words read back their own value
    for (int k = 0; k < 5; k++) wr16(7'(cfg_a[k]), cfg_v[k]);
    for (int k = 0; k < 5; k++) begin
      rd16(7'(cfg_a[k]), rd);
      check($sformatf("R2 R3 cfg readback %0d", k), rd, cfg_v[k]);
    end
    for (int k = 0; k < 5; k++) wr16(7'(cfg_a[k]), 16'h0);

    // R3/R4 on data (software-owned), maskA and maskB, read via every slot (R2)
    for (int g = 0; g < 3; g++) begin
      logic [6:0] base;
      base = 7'(g * 16);
      wr16(base, 16'h00F0);
      rd16(base, rd);        check($sformatf("R3 load grp%0d", g), rd, 16'h00F0);
      wr16(base + 7'd8, 16'h0F01);
      rd16(base, rd);        check($sformatf("R4 set grp%0d", g), rd, 16'h0FF1);
      wr16(base + 7'd4, 16'h0011);
      rd16(base, rd);        check($sformatf("R4 clear grp%0d", g), rd, 16'h0FE0);
      wr16(base + 7'd12, 16'hF0F0);
      for (int s = 0; s < 4; s++) begin
        rd16(base + 7'(s * 4), rd);
        check($sformatf("R2 R4 toggle grp%0d slot%0d", g, s), rd, 16'hFF10);
      end
      wr16(base, 16'h0);
    end

    // R5: illegal accesses flag an error and change nothing
    wr16(A_MSKA, 16'h1111);
    access(1'b1, A_MSKA, 2'b00, 16'hFFFF, rd, er, rv);
    check("R5 byte size err", er, 1); check("R6 rsp on err", rv, 1);
    access(1'b1, A_MSKA, 2'b10, 16'hFFFF, rd, er, rv);
    check("R5 word size err", er, 1);
    access(1'b1, 7'h12, 2'b01, 16'hFFFF, rd, er, rv);
    check("R5 misaligned err", er, 1);
    access(1'b1, 7'h44, 2'b01, 16'hFFFF, rd, er, rv);
    check("R5 out of range err", er, 1);
    access(1'b0, 7'h7C, 2'b01, 16'h0, rd, er, rv);
    check("R5 read out of range err", er, 1); check("R5 err rdata", rd, 0);
    access(1'b0, A_MSKA, 2'b01, 16'h0, rd, er, rv);
    check("R5 mask untouched", rd, 16'h1111); check("R5 legal no err", er, 0);
    check("R6 legal rsp", rv, 1);
    @(negedge clk); check("R6 idle no rsp", rsp_vld, 0);
    wr16(A_MSKA, 16'h0);

    // R7: one gate bit alone is not enough
    wr16(A_DATA, 16'h0000);
    wr16(A_MSKA, 16'h0004); wr16(A_MSKB, 16'h0004);
    wr16(A_EDGE, 16'h0004); wr16(A_BOTH, 16'h0004);
    for (int v = 0; v < 2; v++) begin
      int ca;
      wr16(A_DIR, v == 0 ? 16'h0004 : 16'h0); wr16(A_INEN, v == 0 ? 16'h0 : 16'h0004);
      pins_in = 16'h0004; ca = 0;
      for (int k = 0; k < 8; k++) begin @(negedge clk); ca += int'(irq_a | irq_b); end
      check($sformatf("R7 gated pin no irq v%0d", v), ca, 0);
      rd16(A_DATA, rd); check($sformatf("R7 gated pin data v%0d", v), rd, 16'h0);
      pins_in = 16'h0; idle(4);
    end
    // R7: enabled pin overrides a software write of its data bit
    wr16(A_MSKA, 16'h0); wr16(A_MSKB, 16'h0);
    wr16(A_DIR, 16'h0004); wr16(A_INEN, 16'h0004);
    idle(4);
    wr16(A_DATA, 16'h0104);
    rd16(A_DATA, rd); check("R7 hw wins on owned bit", rd, 16'h0100);

    // R8: latency of a rising edge
    wr16(A_DATA, 16'h0);
    wr16(A_DIR, 16'h0001); wr16(A_INEN, 16'h0001);
    wr16(A_EDGE, 16'h0001); wr16(A_BOTH, 16'h0); wr16(A_POL, 16'h0);
    wr16(A_MSKA, 16'h0001);
    idle(4);
    pins_in = 16'h0001;
    @(negedge clk); check("R8 after edge n", irq_a, 0);
    @(negedge clk); check("R8 after edge n+1", irq_a, 0);
    @(negedge clk); check("R8 after edge n+2", irq_a, 1);
    @(negedge clk); check("R8 after edge n+3", irq_a, 0);
    pins_in = 16'h0; idle(4);

    // R9..R12 sweep
    for (int p = 0; p < 16; p++)
      for (int m = 0; m < 5; m++)
        for (int s = 0; s < 2; s++)
          sense_case(p, m, s[0]);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule